// File: doc/BRIEF.md
# Bit-Manipulation Execution Unit

This unit sits in the execute stage of a 32-bit processor datapath and carries out a group of single-operand data-register operations. Each operation is chosen by a 4-bit select. The operations are bit reversal, byte reversal, leading-one position counting, overflow-driven signed saturation, byte and word sign extension, byte and word zero extension, and loading a small signed immediate. The decoder presents an operand, the select, a 3-bit immediate and the current overflow flag together with a valid strobe.

One clock later the unit presents a registered 32-bit result, a one-cycle result strobe and the updated condition flags: negative, zero, overflow and carry. The reorder operations pass the flags through unchanged. Select codes with no assigned operation are dropped without any effect.

Top module: `bitops_unit`

## Requirements
- R1: While `rst` is high at a clock edge, the unit clears `out_valid`, `result` and all four flags to 0 at that edge.
- R2: When `in_valid` is high with a select in the range 0 to 8, `out_valid` is high after the next clock edge, together with the result of that operation. A cycle with `in_valid` low gives `out_valid` low, and `result` and the flags keep their values.
- R3: Select 0 (bit reverse) makes result bit i equal to operand bit 31-i for every i.
- R4: Select 1 (byte reverse) puts operand byte 0 in result byte 3, byte 1 in byte 2, byte 2 in byte 1 and byte 3 in byte 0.
- R5: Select 2 (leading-one count) returns 31 minus the index of the highest set operand bit. A set bit 31 gives 0, and an all-zero operand gives 32.
- R6: Select 3 (saturate) returns the operand unchanged when `v_in` is 0. When `v_in` is 1 it returns 0x80000000 if operand bit 31 is 0, and 0x7FFFFFFF if operand bit 31 is 1.
- R7: Selects 4 and 5 sign-extend the operand from bit 7 and from bit 15 respectively.
- R8: Selects 6 and 7 clear every result bit above bit 7 and above bit 15 respectively.
- R9: Select 8 loads `imm3` sign-extended: codes 1 to 7 give +1 to +7, and code 0 gives -1 (0xFFFFFFFF).
- R10: For selects 2 to 8, `flag_n` becomes result bit 31, `flag_z` becomes 1 exactly when the result is zero, and `flag_v` and `flag_c` become 0.
- R11: Selects 0 and 1 leave all four flags unchanged.
- R12: Selects 9 to 15 with `in_valid` high give `out_valid` low and leave `result` and the flags unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operation request strobe |
| op | input | 4 | Operation select |
| operand | input | 32 | Source data |
| imm3 | input | 3 | Immediate field for select 8 |
| v_in | input | 1 | Incoming overflow flag used by saturate |
| result | output | 32 | Registered result |
| out_valid | output | 1 | Result strobe, one cycle after a legal request |
| flag_n | output | 1 | Negative flag |
| flag_z | output | 1 | Zero flag |
| flag_v | output | 1 | Overflow flag |
| flag_c | output | 1 | Carry flag |

## Verification
Random operands are mixed with sparse single-bit words, all-zero and all-ones values. Sparse and zero words separate a correct leading-one count from an off-by-one or wrong-direction scan, and they also cover the no-bit-set value of 32. Operands with bit 7, bit 15 or bit 31 set and clear, each tried with `v_in` at both levels, show whether extension uses the correct source bit and whether saturation picks the correct bound. Flag-setting selects are placed right before the reorder and reserved selects, so a pass-through flag or a held result cannot be mistaken for a freshly computed one.

// File: rtl/bitops_unit.sv
module bitops_unit #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_valid,
  input  logic [3:0]   op,
  input  logic [W-1:0] operand,
  input  logic [2:0]   imm3,
  input  logic         v_in,
  output logic [W-1:0] result,
  output logic         out_valid,
  output logic         flag_n,
  output logic         flag_z,
  output logic         flag_v,
  output logic         flag_c
);
  localparam int CW = $clog2(W) + 1;
  localparam int NB = W / 8;
  localparam logic [3:0] OP_BREV = 4'd0, OP_BSWP = 4'd1, OP_LONE = 4'd2,
                         OP_SAT  = 4'd3, OP_SXB  = 4'd4, OP_SXW  = 4'd5,
                         OP_ZXB  = 4'd6, OP_ZXW  = 4'd7, OP_IMM  = 4'd8;

  logic [W-1:0] brev, bswp, lone, sat, nxt;
  logic [CW-1:0] cnt;

  always_comb begin
    for (int i = 0; i < W; i++) brev[i] = operand[W-1-i];
    for (int b = 0; b < NB; b++) bswp[8*b +: 8] = operand[8*(NB-1-b) +: 8];
    cnt = CW'(W);
    for (int i = 0; i < W; i++) if (operand[i]) cnt = CW'(W-1-i);
  end

  assign lone = W'(cnt);
  assign sat  = !v_in ? operand :
                (operand[W-1] ? {1'b0, {(W-1){1'b1}}} : {1'b1, {(W-1){1'b0}}});

  always_comb begin
    case (op)
      OP_BREV: nxt = brev;
      OP_BSWP: nxt = bswp;
      OP_LONE: nxt = lone;
      OP_SAT:  nxt = sat;
      OP_SXB:  nxt = {{(W-8){operand[7]}}, operand[7:0]};
      OP_SXW:  nxt = {{(W-16){operand[15]}}, operand[15:0]};
      OP_ZXB:  nxt = {{(W-8){1'b0}}, operand[7:0]};
      OP_ZXW:  nxt = {{(W-16){1'b0}}, operand[15:0]};
      OP_IMM:  nxt = {{(W-3){imm3 == 3'd0}}, (imm3 == 3'd0) ? 3'b111 : imm3};
      default: nxt = '0;
    endcase
  end

  wire legal    = in_valid && (op <= OP_IMM);
  wire set_flag = in_valid && (op >= OP_LONE) && (op <= OP_IMM);

  always_ff @(posedge clk) begin
    if (rst) begin
      result    <= '0;
      out_valid <= 1'b0;
      {flag_n, flag_z, flag_v, flag_c} <= 4'b0;
    end else begin
      out_valid <= legal;
      if (legal) result <= nxt;
      if (set_flag) begin
        flag_n <= nxt[W-1];
        flag_z <= (nxt == '0);
        flag_v <= 1'b0;
        flag_c <= 1'b0;
      end
    end
  end

  // R1
  reset_clear_chk: assert property (@(posedge clk) rst |=> !out_valid && result == '0);
  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid && $stable(result));
  // R5
  lone_range_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op == OP_LONE) |=> result <= W);
  // R10
  flag_clear_chk: assert property (@(posedge clk) disable iff (rst)
    set_flag |=> !flag_v && !flag_c && (flag_z == (result == '0)) && (flag_n == result[W-1]));
  // R11
  flag_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op <= OP_BSWP) |=> $stable({flag_n, flag_z, flag_v, flag_c}));
  // R12
  reserved_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op > OP_IMM) |=> !out_valid && $stable(result));
endmodule

// File: tb/bitops_unit_tb.sv
module bitops_unit_tb;
  logic clk = 0, rst = 1, in_valid = 0, v_in = 0;
  logic [3:0] op = 0;
  logic [31:0] operand = 0;
  logic [2:0] imm3 = 0;
  logic [31:0] result;
  logic out_valid, flag_n, flag_z, flag_v, flag_c;
  int checks = 0, fails = 0;
  logic [31:0] e_res = 0;
  logic [3:0] e_flg = 0;

  always #5 clk = ~clk;

  bitops_unit u_dut (.clk, .rst, .in_valid, .op, .operand, .imm3, .v_in,
    .result, .out_valid, .flag_n, .flag_z, .flag_v, .flag_c);

  function automatic logic [31:0] model(input logic [3:0] o, input logic [31:0] a,
                                        input logic [2:0] im, input logic v);
    logic [31:0] r = 0;
    case (o)
      0: for (int i = 0; i < 32; i++) r[i] = a[31-i];
      1: r = {a[7:0], a[15:8], a[23:16], a[31:24]};
      2: begin r = 32; for (int i = 31; i >= 0; i--) if (a[i]) begin r = 31 - i; break; end end
      3: r = !v ? a : (a[31] ? 32'h7FFFFFFF : 32'h80000000);
      4: r = {{24{a[7]}}, a[7:0]};
      5: r = {{16{a[15]}}, a[15:0]};
      6: r = {24'd0, a[7:0]};
      7: r = {16'd0, a[15:0]};
      8: r = (im == 0) ? 32'hFFFFFFFF : {29'd0, im};
      default: r = 0;
    endcase
    return r;
  endfunction

  function automatic string tag(input logic [3:0] o);
    case (o)
      0: return "R3/R11"; 1: return "R4/R11"; 2: return "R5/R10"; 3: return "R6/R10";
      4, 5: return "R7/R10"; 6, 7: return "R8/R10"; 8: return "R9/R10";
      default: return "R12";
    endcase
  endfunction

  task automatic compare(input string req, input logic ev);
    checks++;
    if (out_valid !== ev || result !== e_res || {flag_n, flag_z, flag_v, flag_c} !== e_flg) begin
      fails++;
      $display("FAIL %s: got v=%b res=%h nzvc=%b, expected v=%b res=%h nzvc=%b",
               req, out_valid, result, {flag_n, flag_z, flag_v, flag_c}, ev, e_res, e_flg);
    end
  endtask

  task automatic apply(input logic [3:0] o, input logic [31:0] a,
                       input logic [2:0] im, input logic v);
    logic [31:0] r;
    op = o; operand = a; imm3 = im; v_in = v; in_valid = 1;
    @(negedge clk);
    in_valid = 0;
    r = model(o, a, im, v);
    if (o <= 8) e_res = r;
    if (o >= 2 && o <= 8) e_flg = {r[31], r == 0, 2'b00};
    compare(tag(o), o <= 8);
  endtask

  task automatic idle();
    @(negedge clk);
    compare("R2 idle", 1'b0);
  endtask

  initial begin
    #2000000;
    fails++;
    $display("FAIL watchdog: got hang, expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd5150));
    repeat (3) @(negedge clk);
    compare("R1 reset", 1'b0);
    rst = 0;
    // R5 corner cases
    apply(2, 32'h80000000, 0, 0);
    apply(2, 32'h00000001, 0, 0);
    apply(2, 32'h00000000, 0, 0);
    apply(2, 32'h00010F00, 0, 0);
    // R6 both bounds and pass-through
    apply(3, 32'h12345678, 0, 1);
    apply(3, 32'h92345678, 0, 1);
    apply(3, 32'h92345678, 0, 0);
    // R11 flags held across reorder after a flag-setting op
    apply(8, 0, 3'd0, 0);
    apply(0, 32'h00000001, 0, 0);
    apply(1, 32'h11223344, 0, 0);
    // R12 reserved select holds state
    apply(4'd12, 32'hFFFFFFFF, 7, 1);
    idle();
    // R7 R8 sign bits
    apply(4, 32'hABCD0080, 0, 0);
    apply(5, 32'h00008000, 0, 0);
    apply(6, 32'hFFFFFF80, 0, 0);
    apply(7, 32'hFFFF8001, 0, 0);
    // R9 all immediate codes
    for (int k = 0; k < 8; k++) apply(8, 32'hDEADBEEF, 3'(k), 0);
    // R1 reset mid-stream
    rst = 1; @(negedge clk); rst = 0;
    e_res = 0; e_flg = 0;
    compare("R1 reset", 1'b0);
    for (int n = 0; n < 400; n++) begin
      logic [31:0] a;
      case ($urandom_range(0, 3))
        0: a = $urandom();
        1: a = 32'h1 << $urandom_range(0, 31);
        2: a = ($urandom_range(0, 1) != 0) ? 32'h0 : 32'hFFFFFFFF;
        default: a = $urandom() >> $urandom_range(0, 31);
      endcase
      apply(4'($urandom_range(0, 15)), a, 3'($urandom_range(0, 7)), 1'($urandom_range(0, 1)));
      if ($urandom_range(0, 7) == 0) idle();
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule